// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the register file behind a GPIO expander with 8, 16, 24 or 40 pins. The pins are split into 8-bit banks, and a byte-wide register bus reaches them. A serial protocol engine, which is not part of this block, opens a transfer by presenting an address byte. It then moves one data byte per strobe. The block holds the per-pin configuration: output level, polarity inversion, direction, input latching, pull enable, pull select and interrupt mask. It drives the pad-side output enables, output values and pull controls. It also samples the pins through a two-stage synchronizer and keeps a per-pin change status.

An address byte carries four things. Bits 5:0 hold the register kind shifted left by `BANK_SHIFT`, with the bank index in the low `BANK_SHIFT` bits. Bit 6 selects the extended set. Bit 7 requests auto-increment, which moves the pointer to the next bank of the same kind after every data byte and wraps from the last bank back to bank 0. Addresses that name no register are harmless: writes to them are dropped and reads of them return zero.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset every pin is an input (`pins_oe` all zero), the output register reads all ones, polarity inversion, latching and pull enable read zero, the interrupt mask reads all ones and the change status reads zero.
- R2: Address bits 5:0 equal `(kind << BANK_SHIFT) | bank`, where `BANK_SHIFT` is the number of bits needed to hold `(PIN_COUNT-1)/8` (0, 1, 2 and 3 for 8, 16, 24 and 40 pins). With bit 6 clear, the kinds are 0 input, 1 output, 2 polarity and 3 direction. With bit 6 set, they are 2 latch enable, 3 pull enable, 4 pull select, 5 interrupt mask and 6 change status.
- R3: A bank index of `PIN_COUNT/8` or more, or a kind not listed in R2, is an invalid address: a write to it changes nothing and a read of it returns 8'h00.
- R4: The input kind and the change-status kind are read-only; a write to them changes no register.
- R5: With address bit 7 set, each read or write strobe moves the pointer to the next bank of the same kind, and from the last bank to bank 0.
- R6: With address bit 7 clear, strobes leave the pointer where it is, so repeated bytes hit the same register.
- R7: A direction bit of 1 makes the pin an input (`pins_oe` low). A direction bit of 0 sets `pins_oe` high and drives the output register bit on `pins_out`.
- R8: Reading the input kind returns the synchronized pin level XOR the polarity bit, while the latch for that pin is not holding.
- R9: `pull_up_en` is pull enable AND pull select, and `pull_dn_en` is pull enable AND NOT pull select, so a pull acts only while its enable bit is 1.
- R10: A change of the synchronized level on an input pin whose mask bit is 0 sets its change-status bit. A masked pin never sets it. Reading the input kind of a bank clears the status bits of that bank.
- R11: With its latch bit set, a pin that changes keeps returning the level it changed to on input reads until the input kind of its bank is read. After that read it follows the pin again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Loads the address pointer from `xfer_addr`; carries no data |
| xfer_addr | input | 8 | Address byte: bit 7 auto-increment, bit 6 extended set, bits 5:0 kind and bank |
| wr_stb | input | 1 | Writes `wr_data` to the pointed register |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Consumes the byte on `rd_data` (advances the pointer, clears on input read) |
| rd_data | output | 8 | Contents of the pointed register, zero when invalid |
| pins_in | input | PIN_COUNT | Pin levels from the pads |
| pins_out | output | PIN_COUNT | Output levels to the pads |
| pins_oe | output | PIN_COUNT | Output enables to the pads, 1 = drive |
| pull_up_en | output | PIN_COUNT | Pull-up enable per pin |
| pull_dn_en | output | PIN_COUNT | Pull-down enable per pin |

## Verification
The assertions assume that `xfer_start` never comes in the same cycle as a data strobe. The protocol engine spends a full cycle on the address byte, so the pointer properties treat strobes during a start as absent. They also assume that `rd_data` is taken in the cycle of the strobe and not after. The stimulus always pulses `xfer_start` alone for one cycle and samples `rd_data` before raising `rd_stb`. It holds pin levels steady for several cycles around every check, so the two-stage synchronizer has settled before a value is compared.

// File: rtl/gpio_xp_pkg.sv
package gpio_xp_pkg;

  typedef enum logic [3:0] {
    RK_INPUT,
    RK_OUTPUT,
    RK_POLAR,
    RK_DIR,
    RK_LATCH,
    RK_PULLEN,
    RK_PULLSEL,
    RK_MASK,
    RK_STATUS,
    RK_NONE
  } reg_kind_e;

  // bits needed to hold the highest bank index
  function automatic int unsigned bank_bits(int unsigned pins);
    int unsigned top_idx;
    int unsigned n;
    top_idx = (pins - 1) / 8;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if ((top_idx >> i) != 0) n = i + 1;
    end
    return n;
  endfunction

  // map set flag and kind code to a register kind (R2)
  function automatic reg_kind_e classify(logic ext, logic [5:0] kind);
    reg_kind_e r;
    r = RK_NONE;
    if (!ext) begin
      case (kind)
        6'd0:    r = RK_INPUT;
        6'd1:    r = RK_OUTPUT;
        6'd2:    r = RK_POLAR;
        6'd3:    r = RK_DIR;
        default: r = RK_NONE;
      endcase
    end else begin
      case (kind)
        6'd2:    r = RK_LATCH;
        6'd3:    r = RK_PULLEN;
        6'd4:    r = RK_PULLSEL;
        6'd5:    r = RK_MASK;
        6'd6:    r = RK_STATUS;
        default: r = RK_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_xp_addr_split.sv
module gpio_xp_addr_split #(
  parameter int unsigned BANK_SHIFT = 1
) (
  input  logic [7:0] addr,
  output logic       auto_inc,
  output logic       ext_set,
  output logic [5:0] kind,
  output logic [2:0] bank
);

  localparam logic [2:0] BANK_MASK = 3'((1 << BANK_SHIFT) - 1);

  assign auto_inc = addr[7];
  assign ext_set  = addr[6];
  assign kind     = 6'(addr[5:0] >> BANK_SHIFT);
  assign bank     = addr[2:0] & BANK_MASK;

endmodule

// File: rtl/gpio_xp_cfg_store.sv
module gpio_xp_cfg_store
  import gpio_xp_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 16,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_kind_e            wr_kind,
  input  logic [2:0]           wr_bank,
  input  logic [7:0]           wr_data,
  output logic [PIN_COUNT-1:0] out_q,
  output logic [PIN_COUNT-1:0] polar_q,
  output logic [PIN_COUNT-1:0] dir_q,
  output logic [PIN_COUNT-1:0] latch_q,
  output logic [PIN_COUNT-1:0] pullen_q,
  output logic [PIN_COUNT-1:0] pullsel_q,
  output logic [PIN_COUNT-1:0] mask_q
);

  logic [PIN_COUNT-1:0] out_d, polar_d, dir_d, latch_d, pullen_d, pullsel_d, mask_d;

  always_comb begin
    out_d     = out_q;
    polar_d   = polar_q;
    dir_d     = dir_q;
    latch_d   = latch_q;
    pullen_d  = pullen_q;
    pullsel_d = pullsel_q;
    mask_d    = mask_q;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (wr_en && (wr_bank == 3'(b))) begin
        case (wr_kind)
          RK_OUTPUT:  out_d[b*8 +: 8]     = wr_data;
          RK_POLAR:   polar_d[b*8 +: 8]   = wr_data;
          RK_DIR:     dir_d[b*8 +: 8]     = wr_data;
          RK_LATCH:   latch_d[b*8 +: 8]   = wr_data;
          RK_PULLEN:  pullen_d[b*8 +: 8]  = wr_data;
          RK_PULLSEL: pullsel_d[b*8 +: 8] = wr_data;
          RK_MASK:    mask_d[b*8 +: 8]    = wr_data;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '1;
      polar_q   <= '0;
      dir_q     <= '1;
      latch_q   <= '0;
      pullen_q  <= '0;
      pullsel_q <= '0;
      mask_q    <= '1;
    end else if (wr_en) begin
      out_q     <= out_d;
      polar_q   <= polar_d;
      dir_q     <= dir_d;
      latch_q   <= latch_d;
      pullen_q  <= pullen_d;
      pullsel_q <= pullsel_d;
      mask_q    <= mask_d;
    end
  end

endmodule

// File: rtl/gpio_xp_input_path.sv
module gpio_xp_input_path #(
  parameter int unsigned PIN_COUNT = 16,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_COUNT-1:0] pins_in,
  input  logic [PIN_COUNT-1:0] dir_q,
  input  logic [PIN_COUNT-1:0] polar_q,
  input  logic [PIN_COUNT-1:0] latch_q,
  input  logic [PIN_COUNT-1:0] mask_q,
  input  logic [NUM_BANKS-1:0] clr_bank,
  output logic [PIN_COUNT-1:0] in_val,
  output logic [PIN_COUNT-1:0] stat_q
);

  logic [PIN_COUNT-1:0] meta_q, sync_q, prev_q, held_q, pend_q;
  logic [PIN_COUNT-1:0] level, event_v, clr_vec;
  logic [PIN_COUNT-1:0] stat_d, pend_d, held_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_clr
    assign clr_vec[b*8 +: 8] = {8{clr_bank[b]}};
  end

  assign level   = sync_q ^ polar_q;
  assign event_v = (sync_q ^ prev_q) & dir_q;

  always_comb begin
    stat_d = (stat_q & ~clr_vec) | (event_v & ~mask_q);
    pend_d = ((pend_q & ~clr_vec) | event_v) & latch_q;
    held_d = (held_q & pend_q) | (level & ~pend_q);
  end

  assign in_val = (held_q & pend_q) | (level & ~pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      held_q <= '0;
      pend_q <= '0;
      stat_q <= '0;
    end else begin
      meta_q <= pins_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
      held_q <= held_d;
      pend_q <= pend_d;
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_xp_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer_start,
  input  logic [7:0]           xfer_addr,
  input  logic                 wr_stb,
  input  logic [7:0]           wr_data,
  input  logic                 rd_stb,
  output logic [7:0]           rd_data,
  input  logic [PIN_COUNT-1:0] pins_in,
  output logic [PIN_COUNT-1:0] pins_out,
  output logic [PIN_COUNT-1:0] pins_oe,
  output logic [PIN_COUNT-1:0] pull_up_en,
  output logic [PIN_COUNT-1:0] pull_dn_en
);

  localparam int unsigned NUM_BANKS  = (PIN_COUNT + 7) / 8;
  localparam int unsigned BANK_SHIFT = bank_bits(PIN_COUNT);
  localparam logic [2:0]  LAST_BANK  = 3'(NUM_BANKS - 1);

  // address pointer
  logic       ptr_ai, ptr_ext;
  logic [5:0] ptr_kind;
  logic [2:0] ptr_bank;
  logic       ptr_ai_d, ptr_ext_d;
  logic [5:0] ptr_kind_d;
  logic [2:0] ptr_bank_d;

  logic       a_ai, a_ext;
  logic [5:0] a_kind;
  logic [2:0] a_bank;

  reg_kind_e  cur_kind;
  logic       cur_valid, cur_wr_ok, access, wr_en;
  logic [NUM_BANKS-1:0] clr_bank;

  logic [PIN_COUNT-1:0] out_q, polar_q, dir_q, latch_q, pullen_q, pullsel_q, mask_q;
  logic [PIN_COUNT-1:0] in_val, stat_q, rd_vec;
  logic [7:0]           rd_byte;

  gpio_xp_addr_split #(.BANK_SHIFT(BANK_SHIFT)) split_i (
    .addr     (xfer_addr),
    .auto_inc (a_ai),
    .ext_set  (a_ext),
    .kind     (a_kind),
    .bank     (a_bank)
  );

  assign cur_kind  = classify(ptr_ext, ptr_kind);
  assign cur_valid = (cur_kind != RK_NONE) && (ptr_bank < 3'(NUM_BANKS));
  assign cur_wr_ok = cur_valid && (cur_kind != RK_INPUT) && (cur_kind != RK_STATUS);
  assign access    = (rd_stb || wr_stb) && !xfer_start;
  assign wr_en     = wr_stb && !xfer_start && cur_wr_ok;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_clr
    assign clr_bank[b] = rd_stb && !xfer_start && cur_valid &&
                         (cur_kind == RK_INPUT) && (ptr_bank == 3'(b));
  end

  // pointer next state
  always_comb begin
    ptr_ai_d   = ptr_ai;
    ptr_ext_d  = ptr_ext;
    ptr_kind_d = ptr_kind;
    ptr_bank_d = ptr_bank;
    if (xfer_start) begin
      ptr_ai_d   = a_ai;
      ptr_ext_d  = a_ext;
      ptr_kind_d = a_kind;
      ptr_bank_d = a_bank;
    end else if (access && ptr_ai) begin
      ptr_bank_d = (ptr_bank >= LAST_BANK) ? 3'd0 : ptr_bank + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_ai   <= 1'b0;
      ptr_ext  <= 1'b0;
      ptr_kind <= '0;
      ptr_bank <= '0;
    end else if (xfer_start || access) begin
      ptr_ai   <= ptr_ai_d;
      ptr_ext  <= ptr_ext_d;
      ptr_kind <= ptr_kind_d;
      ptr_bank <= ptr_bank_d;
    end
  end

  gpio_xp_cfg_store #(.PIN_COUNT(PIN_COUNT), .NUM_BANKS(NUM_BANKS)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_kind   (cur_kind),
    .wr_bank   (ptr_bank),
    .wr_data   (wr_data),
    .out_q     (out_q),
    .polar_q   (polar_q),
    .dir_q     (dir_q),
    .latch_q   (latch_q),
    .pullen_q  (pullen_q),
    .pullsel_q (pullsel_q),
    .mask_q    (mask_q)
  );

  gpio_xp_input_path #(.PIN_COUNT(PIN_COUNT), .NUM_BANKS(NUM_BANKS)) inp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_in  (pins_in),
    .dir_q    (dir_q),
    .polar_q  (polar_q),
    .latch_q  (latch_q),
    .mask_q   (mask_q),
    .clr_bank (clr_bank),
    .in_val   (in_val),
    .stat_q   (stat_q)
  );

  // read path: kind then bank
  always_comb begin
    case (cur_kind)
      RK_INPUT:   rd_vec = in_val;
      RK_OUTPUT:  rd_vec = out_q;
      RK_POLAR:   rd_vec = polar_q;
      RK_DIR:     rd_vec = dir_q;
      RK_LATCH:   rd_vec = latch_q;
      RK_PULLEN:  rd_vec = pullen_q;
      RK_PULLSEL: rd_vec = pullsel_q;
      RK_MASK:    rd_vec = mask_q;
      RK_STATUS:  rd_vec = stat_q;
      default:    rd_vec = '0;
    endcase
    rd_byte = 8'h00;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (ptr_bank == 3'(b)) rd_byte = rd_vec[b*8 +: 8];
    end
  end

  assign rd_data    = cur_valid ? rd_byte : 8'h00;
  assign pins_out   = out_q;
  assign pins_oe    = ~dir_q;
  assign pull_up_en = pullen_q & pullsel_q;
  assign pull_dn_en = pullen_q & ~pullsel_q;

endmodule

// File: rtl/gpio_xp_checker.sv
module gpio_xp_checker
  import gpio_xp_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 xfer_start,
  input logic [7:0]           xfer_addr,
  input logic                 wr_stb,
  input logic                 rd_stb,
  input logic [7:0]           rd_data,
  input logic [PIN_COUNT-1:0] pins_out,
  input logic [PIN_COUNT-1:0] pins_oe,
  input logic [PIN_COUNT-1:0] pull_up_en,
  input logic [PIN_COUNT-1:0] pull_dn_en,
  input logic                 ptr_ai,
  input logic [2:0]           ptr_bank,
  input logic                 cur_valid,
  input reg_kind_e            cur_kind
);

  localparam int unsigned NB = (PIN_COUNT + 7) / 8;
  localparam int unsigned SH = bank_bits(PIN_COUNT);

  logic [5:0] start_bank;
  logic       strobe;
  assign start_bank = xfer_addr[5:0] % 6'(1 << SH);
  assign strobe     = (rd_stb || wr_stb) && !xfer_start;

  // R3: pointing at a bank past the last one reads zero
  assert_bad_bank_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start && (start_bank >= 6'(NB)) |=> rd_data == 8'h00);

  // R3: writes to invalid addresses leave every pad control unchanged
  assert_bad_write_no_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !xfer_start && !cur_valid |=>
      $stable(pins_out) && $stable(pins_oe) && $stable(pull_up_en) && $stable(pull_dn_en));

  // R4: read-only kinds ignore writes
  assert_ro_write_no_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !xfer_start && cur_valid && ((cur_kind == RK_INPUT) || (cur_kind == RK_STATUS)) |=>
      $stable(pins_out) && $stable(pins_oe) && $stable(pull_up_en) && $stable(pull_dn_en));

  // R5: auto-increment steps to the next bank
  assert_ai_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && ptr_ai && (ptr_bank < 3'(NB - 1)) |=> ptr_bank == 3'($past(ptr_bank) + 3'd1));

  // R5: auto-increment wraps after the last bank
  assert_ai_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && ptr_ai && (ptr_bank == 3'(NB - 1)) |=> ptr_bank == 3'd0);

  // R6: without auto-increment the pointer stays put
  assert_no_ai_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !ptr_ai |=> $stable(ptr_bank));

endmodule

bind gpio_bank_regfile gpio_xp_checker #(.PIN_COUNT(PIN_COUNT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_start (xfer_start),
  .xfer_addr  (xfer_addr),
  .wr_stb     (wr_stb),
  .rd_stb     (rd_stb),
  .rd_data    (rd_data),
  .pins_out   (pins_out),
  .pins_oe    (pins_oe),
  .pull_up_en (pull_up_en),
  .pull_dn_en (pull_dn_en),
  .ptr_ai     (ptr_ai),
  .ptr_bank   (ptr_bank),
  .cur_valid  (cur_valid),
  .cur_kind   (cur_kind)
);

// File: tb/gpio_bank_regfile_tb_top.sv
module gpio_bank_regfile_tb_top;

  localparam int PINS = 24;   // 3 banks, bank field 2 bits
  localparam int NB   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            xfer_start = 1'b0;
  logic [7:0]      xfer_addr = 8'h00;
  logic            wr_stb = 1'b0;
  logic [7:0]      wr_data = 8'h00;
  logic            rd_stb = 1'b0;
  logic [7:0]      rd_data;
  logic [PINS-1:0] pins_in = '0;
  logic [PINS-1:0] pins_out, pins_oe, pull_up_en, pull_dn_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the writable registers
  logic [PINS-1:0] m_out, m_pol, m_dir, m_lat, m_pen, m_psel, m_msk;

  always #4 clk = ~clk;   // 8 ns period, 125 MHz

  gpio_bank_regfile #(.PIN_COUNT(PINS)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_addr  (xfer_addr),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .pins_in    (pins_in),
    .pins_out   (pins_out),
    .pins_oe    (pins_oe),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_out = '1; m_pol = '0; m_dir = '1; m_lat = '0;
    m_pen = '0; m_psel = '0; m_msk = '1;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start(input logic [7:0] a);
    xfer_addr  = a;
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] v);
    v = rd_data;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  // expected read of address a: bank = a[1:0], kind = a[5:2], set = a[6]
  function automatic logic [7:0] model_rd(input logic [7:0] a);
    int bk;
    int kd;
    logic [PINS-1:0] v;
    bk = int'(a[1:0]);
    kd = int'(a[5:2]);
    if (bk >= NB) return 8'h00;
    if (!a[6]) begin
      case (kd)
        0: v = pins_in ^ m_pol;
        1: v = m_out;
        2: v = m_pol;
        3: v = m_dir;
        default: return 8'h00;
      endcase
    end else begin
      case (kd)
        2: v = m_lat;
        3: v = m_pen;
        4: v = m_psel;
        5: v = m_msk;
        6: v = '0;
        default: return 8'h00;
      endcase
    end
    return v[bk*8 +: 8];
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    int bk;
    int kd;
    bk = int'(a[1:0]);
    kd = int'(a[5:2]);
    if (bk >= NB) return;
    if (!a[6]) begin
      case (kd)
        1: m_out[bk*8 +: 8] = d;
        2: m_pol[bk*8 +: 8] = d;
        3: m_dir[bk*8 +: 8] = d;
        default: ;
      endcase
    end else begin
      case (kd)
        2: m_lat[bk*8 +: 8]  = d;
        3: m_pen[bk*8 +: 8]  = d;
        4: m_psel[bk*8 +: 8] = d;
        5: m_msk[bk*8 +: 8]  = d;
        default: ;
      endcase
    end
  endtask

  task automatic read_sweep(input string tag);
    logic [7:0] v;
    for (int a = 0; a < 256; a++) begin
      do_start(8'(a));
      rd_byte(v);
      chk(tag, {24'h0, v}, {24'h0, model_rd(8'(a))});
    end
  endtask

  task automatic check_pads(input string tag);
    chk({tag, " R7 oe"},   {8'h0, pins_oe},    {8'h0, ~m_dir});
    chk({tag, " R7 out"},  {8'h0, pins_out},   {8'h0, m_out});
    chk({tag, " R9 up"},   {8'h0, pull_up_en}, {8'h0, m_pen & m_psel});
    chk({tag, " R9 down"}, {8'h0, pull_dn_en}, {8'h0, m_pen & ~m_psel});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    model_reset();
    pins_in = 24'hA53C96;
    apply_reset();

    // R1 reset state, R2/R3/R8 decode over every address
    check_pads("R1 reset");
    read_sweep("R1 R2 R3 R8 reset sweep");

    // R2 R3 R4 write sweep over every address, then full read-back
    for (int a = 0; a < 256; a++) begin
      logic [7:0] d;
      d = 8'((a * 37 + 11) & 8'hFF);
      do_start(8'(a));
      wr_byte(d);
      model_wr(8'(a), d);
    end
    read_sweep("R2 R3 R4 R8 write sweep");
    check_pads("R7 R9 after sweep");

    // R5 auto-increment on the output kind, with wrap
    apply_reset();
    do_start(8'h84);
    wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33); wr_byte(8'h44);
    chk("R5 ai write wrap", {8'h0, pins_out}, 32'h00332244);
    do_start(8'h84);
    rd_byte(v); chk("R5 ai read b0", {24'h0, v}, 32'h44);
    rd_byte(v); chk("R5 ai read b1", {24'h0, v}, 32'h22);
    rd_byte(v); chk("R5 ai read b2", {24'h0, v}, 32'h33);
    rd_byte(v); chk("R5 ai read wrap", {24'h0, v}, 32'h44);

    // R6 no auto-increment: both bytes hit polarity bank 0
    do_start(8'h08);
    wr_byte(8'h0F); wr_byte(8'hF0);
    do_start(8'h08); rd_byte(v); chk("R6 same reg", {24'h0, v}, 32'hF0);
    do_start(8'h09); rd_byte(v); chk("R6 next bank untouched", {24'h0, v}, 32'h00);
    chk("R6 pins_out untouched", {8'h0, pins_out}, 32'h00332244);

    // R7 direction bank 1 to outputs
    do_start(8'h0D); wr_byte(8'h00);
    chk("R7 oe bank1", {8'h0, pins_oe}, 32'h0000FF00);

    // R9 pull controls on bank 2
    do_start(8'h4E); wr_byte(8'hFF);
    do_start(8'h52); wr_byte(8'h0F);
    chk("R9 pull up", {8'h0, pull_up_en}, 32'h000F0000);
    chk("R9 pull down", {8'h0, pull_dn_en}, 32'h00F00000);

    // R4 write to input and status kinds leaves pads alone
    do_start(8'h00); wr_byte(8'h5A);
    do_start(8'h58); wr_byte(8'h5A);
    chk("R4 ro write oe", {8'h0, pins_oe}, 32'h0000FF00);
    chk("R4 ro write out", {8'h0, pins_out}, 32'h00332244);

    // R10 change status
    pins_in = '0;
    apply_reset();
    do_start(8'h54); wr_byte(8'h00);          // unmask bank 0
    pins_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    do_start(8'h58); rd_byte(v); chk("R10 status set", {24'h0, v}, 32'h01);
    do_start(8'h00); rd_byte(v); chk("R8 input bank0", {24'h0, v}, 32'h01);
    do_start(8'h58); rd_byte(v); chk("R10 status cleared by input read", {24'h0, v}, 32'h00);
    pins_in[8] = 1'b1;
    repeat (5) @(negedge clk);
    do_start(8'h59); rd_byte(v); chk("R10 masked pin no status", {24'h0, v}, 32'h00);
    do_start(8'h01); rd_byte(v); chk("R8 input bank1", {24'h0, v}, 32'h01);

    // R11 latch on pin 1
    do_start(8'h48); wr_byte(8'h02);
    pins_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    pins_in[1] = 1'b0;
    repeat (5) @(negedge clk);
    do_start(8'h00); rd_byte(v); chk("R11 latched level held", {24'h0, v}, 32'h03);
    do_start(8'h00); rd_byte(v); chk("R11 released after read", {24'h0, v}, 32'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule